// File: doc/BRIEF.md
# Pipelined Rotate/Vector CORDIC

This block is a fixed-point CORDIC made of unrolled shift-and-add stages, with a register after every stage. It accepts one input vector on every clock and returns one result per clock after a fixed latency. Each sample carries its own mode bit, so rotation and vectoring samples can be mixed freely in the same stream.

In rotation mode the block turns the vector (x, y) by the angle z and returns the rotated pair. In vectoring mode it drives y toward zero. It returns the magnitude on the x output and the angle of the vector on the z output. Angles are two's complement with a full turn equal to 2^AW. The stages carry an inherent gain of about 1.647. A constant multiply after the last stage corrects this gain when `COMP` is 1, which is the default. The mode bit and the valid flag move down the pipeline alongside the data.

Top module: `cordic_pipe`

## Requirements
- R1: A sample presented with `valid_in` high on any clock, including back-to-back clocks, produces `valid_out` high exactly LAT = STAGES+2 clocks later. `valid_out` is low on every clock that does not match an accepted input.
- R2: In rotation (`mode_in` = 0), with the default gain correction, `x_out`/`y_out` match x·cosθ − y·sinθ and x·sinθ + y·cosθ to within 4 LSB for angles in [−90°, +90°].
- R3: In vectoring (`mode_in` = 1), `x_out` is non-negative and equals sqrt(x²+y²) to within 4 LSB.
- R4: In vectoring, `z_out` equals atan2(y, x) to within 4 angle LSB, taken modulo a full turn.
- R5: Both modes converge over the whole circle. This covers rotation angles beyond ±90° (including −180°) and vectoring inputs with negative x, in all quadrants.
- R6: `mode_out` equals the mode of the sample whose result is currently valid.
- R7: A synchronous reset clears `valid_out` on the next clock and discards every sample in flight.
- R8: Angle encoding: z is two's complement with a full turn of 2^AW. With AW = 16, 0x4000 is +90°, 0xC000 is −90° and 0x8000 is −180°.
- R9: In vectoring, the residual `y_out` lies within ±4 LSB of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Input sample present |
| mode_in | input | 1 | 0 = rotate by z_in, 1 = vector (find magnitude and angle) |
| x_in | input | DW | Signed x component |
| y_in | input | DW | Signed y component |
| z_in | input | AW | Rotation angle, full turn = 2^AW (ignored in vectoring) |
| valid_out | output | 1 | Result present |
| mode_out | output | 1 | Mode of the result present |
| x_out | output | DW+2 | Rotated x, or magnitude |
| y_out | output | DW+2 | Rotated y, or residual near zero |
| z_out | output | AW | Residual angle, or vector angle |

## Verification
The hardest situation to reach is many samples of both modes in flight at once, each with a different pre-rotation quadrant, while the valid pattern has gaps. The bench creates it with a back-to-back stream whose valid bit drops every third clock and whose mode alternates every clock. It then checks valid, mode and value on every output clock. A second hard case is a reset that arrives while the pipeline is full. The bench fills the stages, pulses reset, and confirms that none of the discarded samples emerges.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  typedef enum logic {
    MODE_ROTATE = 1'b0,
    MODE_VECTOR = 1'b1
  } cordic_mode_e;

  // reciprocal of the stage gain (about 1/1.64676) in Q0.16
  localparam int unsigned GAIN_INV_Q16 = 39797;

  // atan(2^-n) expressed as a fraction of a full turn scaled by 2^32
  function automatic logic [31:0] atan_turn32(input int n);
    case (n)
      0:  atan_turn32 = 32'h20000000;
      1:  atan_turn32 = 32'h12E4051E;
      2:  atan_turn32 = 32'h09FB385B;
      3:  atan_turn32 = 32'h051111D4;
      4:  atan_turn32 = 32'h028B0D43;
      5:  atan_turn32 = 32'h0145D7E1;
      6:  atan_turn32 = 32'h00A2F61E;
      7:  atan_turn32 = 32'h00517C55;
      8:  atan_turn32 = 32'h0028BE53;
      9:  atan_turn32 = 32'h00145F2F;
      10: atan_turn32 = 32'h000A2F98;
      11: atan_turn32 = 32'h000517CC;
      12: atan_turn32 = 32'h00028BE6;
      13: atan_turn32 = 32'h000145F3;
      14: atan_turn32 = 32'h0000A2FA;
      15: atan_turn32 = 32'h0000517D;
      16: atan_turn32 = 32'h000028BE;
      17: atan_turn32 = 32'h0000145F;
      18: atan_turn32 = 32'h00000A30;
      19: atan_turn32 = 32'h00000518;
      20: atan_turn32 = 32'h0000028C;
      21: atan_turn32 = 32'h00000146;
      22: atan_turn32 = 32'h000000A3;
      23: atan_turn32 = 32'h00000051;
      24: atan_turn32 = 32'h00000029;
      25: atan_turn32 = 32'h00000014;
      26: atan_turn32 = 32'h0000000A;
      27: atan_turn32 = 32'h00000005;
      28: atan_turn32 = 32'h00000003;
      29: atan_turn32 = 32'h00000001;
      30: atan_turn32 = 32'h00000001;
      default: atan_turn32 = 32'h00000000;
    endcase
  endfunction

endpackage

// File: rtl/cordic_prerot.sv
// Quadrant fold: moves every input into the right half-plane (R5)
module cordic_prerot #(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int FRAC = 3,
  parameter int IW   = DW + 2 + FRAC
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  logic                 mode_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic        [AW-1:0] z_i,
  output logic                 vld_o,
  output logic                 mode_o,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic        [AW-1:0] z_o
);
  localparam int EXT = IW - DW - FRAC;
  localparam logic [AW-1:0] QUARTER = {2'b01, {(AW-2){1'b0}}};

  logic signed [IW-1:0] xe, ye, xn, yn;
  logic        [AW-1:0] zn;

  assign xe = {{EXT{x_i[DW-1]}}, x_i, {FRAC{1'b0}}};
  assign ye = {{EXT{y_i[DW-1]}}, y_i, {FRAC{1'b0}}};

  always_comb begin
    xn = xe;
    yn = ye;
    zn = z_i;
    if (mode_i == cordic_pkg::MODE_VECTOR) begin
      zn = '0;
      if (xe[IW-1]) begin
        if (!ye[IW-1]) begin
          xn = ye;  yn = -xe; zn = QUARTER;
        end else begin
          xn = -ye; yn = xe;  zn = -QUARTER;
        end
      end
    end else begin
      case (z_i[AW-1:AW-2])
        2'b01: begin xn = -ye; yn = xe;  zn = z_i - QUARTER; end
        2'b10: begin xn = ye;  yn = -xe; zn = z_i + QUARTER; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    mode_o <= mode_i;
    x_o    <= xn;
    y_o    <= yn;
    z_o    <= zn;
  end
endmodule

// File: rtl/cordic_stage.sv
// One micro-rotation by atan(2^-SHIFT), registered
module cordic_stage #(
  parameter int            IW    = 21,
  parameter int            AW    = 16,
  parameter int            SHIFT = 0,
  parameter logic [AW-1:0] ANGLE = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  logic                 mode_i,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic        [AW-1:0] z_i,
  output logic                 vld_o,
  output logic                 mode_o,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic        [AW-1:0] z_o
);
  logic                 ccw;
  logic signed [IW-1:0] xs, ys;

  // rotate counter-clockwise when the residual angle is non-negative,
  // or (vectoring) when y is below the axis
  assign ccw = (mode_i == cordic_pkg::MODE_VECTOR) ? y_i[IW-1] : ~z_i[AW-1];
  assign xs  = x_i >>> SHIFT;
  assign ys  = y_i >>> SHIFT;

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    mode_o <= mode_i;
    if (ccw) begin
      x_o <= x_i - ys;
      y_o <= y_i + xs;
      z_o <= z_i - ANGLE;
    end else begin
      x_o <= x_i + ys;
      y_o <= y_i - xs;
      z_o <= z_i + ANGLE;
    end
  end
endmodule

// File: rtl/cordic_scale.sv
// Output scaling: optional gain correction, then rounding to the output grid
module cordic_scale #(
  parameter int IW   = 21,
  parameter int OW   = 18,
  parameter int FRAC = 3,
  parameter bit COMP = 1'b1
) (
  input  logic                 clk,
  input  logic signed [IW-1:0] v_i,
  output logic signed [OW-1:0] v_o
);
  localparam int PW = IW + 18;
  localparam int SH = 16 + FRAC;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SH - 1);

  logic signed [PW-1:0] prod, rounded;

  generate
    if (COMP) begin : g_comp
      assign prod = v_i * $signed(18'(cordic_pkg::GAIN_INV_Q16));
    end else begin : g_raw
      assign prod = PW'(v_i) <<< 16;
    end
  endgenerate

  assign rounded = prod + HALF;

  always_ff @(posedge clk) begin
    v_o <= rounded[SH +: OW];
  end
endmodule

// File: rtl/cordic_pipe.sv
module cordic_pipe #(
  parameter int DW     = 16,
  parameter int AW     = 16,
  parameter int STAGES = 16,
  parameter int FRAC   = 3,
  parameter bit COMP   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_in,
  input  logic                 mode_in,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] y_in,
  input  logic        [AW-1:0] z_in,
  output logic                 valid_out,
  output logic                 mode_out,
  output logic signed [DW+1:0] x_out,
  output logic signed [DW+1:0] y_out,
  output logic        [AW-1:0] z_out
);
  localparam int IW  = DW + 2 + FRAC;
  localparam int OW  = DW + 2;
  localparam int LAT = STAGES + 2;

  logic                 vld_s  [0:STAGES];
  logic                 mode_s [0:STAGES];
  logic signed [IW-1:0] x_s    [0:STAGES];
  logic signed [IW-1:0] y_s    [0:STAGES];
  logic        [AW-1:0] z_s    [0:STAGES];

  cordic_prerot #(.DW(DW), .AW(AW), .FRAC(FRAC), .IW(IW)) u_fold (
    .clk(clk), .rst(rst),
    .vld_i(valid_in), .mode_i(mode_in), .x_i(x_in), .y_i(y_in), .z_i(z_in),
    .vld_o(vld_s[0]), .mode_o(mode_s[0]), .x_o(x_s[0]), .y_o(y_s[0]), .z_o(z_s[0])
  );

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      localparam logic [31:0] T32 = cordic_pkg::atan_turn32(i);
      localparam logic [32:0] RND = {1'b0, T32} + (33'd1 << (31 - AW));
      localparam logic [AW-1:0] ANG = RND[32-AW +: AW];

      cordic_stage #(.IW(IW), .AW(AW), .SHIFT(i), .ANGLE(ANG)) u_stage (
        .clk(clk), .rst(rst),
        .vld_i(vld_s[i]), .mode_i(mode_s[i]),
        .x_i(x_s[i]), .y_i(y_s[i]), .z_i(z_s[i]),
        .vld_o(vld_s[i+1]), .mode_o(mode_s[i+1]),
        .x_o(x_s[i+1]), .y_o(y_s[i+1]), .z_o(z_s[i+1])
      );
    end
  endgenerate

  cordic_scale #(.IW(IW), .OW(OW), .FRAC(FRAC), .COMP(COMP)) u_scale_x (
    .clk(clk), .v_i(x_s[STAGES]), .v_o(x_out)
  );

  cordic_scale #(.IW(IW), .OW(OW), .FRAC(FRAC), .COMP(COMP)) u_scale_y (
    .clk(clk), .v_i(y_s[STAGES]), .v_o(y_out)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_out <= 1'b0;
    else     valid_out <= vld_s[STAGES];
  end

  always_ff @(posedge clk) begin
    mode_out <= mode_s[STAGES];
    z_out    <= z_s[STAGES];
  end
endmodule

// File: rtl/cordic_pipe_chk.sv
module cordic_pipe_chk #(
  parameter int OW  = 18,
  parameter int LAT = 18
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 valid_in,
  input logic                 valid_out,
  input logic                 mode_out,
  input logic signed [OW-1:0] x_out,
  input logic signed [OW-1:0] y_out
);
  localparam int CW = $clog2(LAT + 2) + 1;

  logic [CW-1:0] in_flight;

  always_ff @(posedge clk) begin
    if (rst) in_flight <= '0;
    else     in_flight <= in_flight + CW'(valid_in) - CW'(valid_out);
  end

  // R1: never more samples in flight than pipeline slots
  p_inflight_bound_r1: assert property (@(posedge clk) disable iff (rst)
    in_flight <= CW'(LAT));

  // R1: no output without an accepted input in flight
  p_out_has_source_r1: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> in_flight != '0);

  // R7: reset empties the output
  p_reset_idle_r7: assert property (@(posedge clk)
    rst |=> !valid_out);

  // R3: vectoring magnitude is never negative
  p_vec_mag_sign_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_out && mode_out) |-> !x_out[OW-1]);

  // R9: vectoring drives y close to zero
  p_vec_residual_r9: assert property (@(posedge clk) disable iff (rst)
    (valid_out && mode_out) |-> (y_out <= 4 && y_out >= -4));
endmodule

bind cordic_pipe cordic_pipe_chk #(.OW(OW), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .valid_in(valid_in), .valid_out(valid_out),
  .mode_out(mode_out), .x_out(x_out), .y_out(y_out)
);

// File: tb/tb_cordic_pipe.sv
module tb_cordic_pipe;
  localparam int DW     = 16;
  localparam int AW     = 16;
  localparam int STAGES = 16;
  localparam int LAT    = STAGES + 2;
  localparam int NSTR   = 40;
  localparam real PI    = 3.14159265358979;
  localparam real TURN  = 65536.0;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 valid_in = 1'b0;
  logic                 mode_in = 1'b0;
  logic signed [DW-1:0] x_in = '0;
  logic signed [DW-1:0] y_in = '0;
  logic        [AW-1:0] z_in = '0;
  logic                 valid_out;
  logic                 mode_out;
  logic signed [DW+1:0] x_out;
  logic signed [DW+1:0] y_out;
  logic        [AW-1:0] z_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cordic_pipe #(.DW(DW), .AW(AW), .STAGES(STAGES)) dut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .mode_in(mode_in),
    .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .valid_out(valid_out), .mode_out(mode_out),
    .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  always #5ns clk = ~clk;

  function automatic real rabs(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic chk_near(input string req, input string what,
                          input real act, input real exp, input real tol);
    checks++;
    if (rabs(act - exp) > tol) begin
      errors++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  task automatic chk_angle(input string req, input string what,
                           input int act, input real exp, input real tol);
    real d;
    d = real'(act) - exp;
    while (d > TURN / 2.0) d = d - TURN;
    while (d < -TURN / 2.0) d = d + TURN;
    checks++;
    if (rabs(d) > tol) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0.2f", req, what, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string what,
                         input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // one isolated sample; returns outputs LAT clocks later
  task automatic run_one(input logic m, input int x, input int y, input int z,
                         output int ox, output int oy, output int oz,
                         output logic ov);
    @(negedge clk);
    mode_in = m; x_in = DW'(x); y_in = DW'(y); z_in = AW'(z);
    valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    ov = valid_out;
    ox = int'(x_out); oy = int'(y_out); oz = int'(z_out);
  endtask

  function automatic real rot_x(int x, int y, int z);
    real a = real'($signed(16'(z))) * 2.0 * PI / TURN;
    return real'(x) * $cos(a) - real'(y) * $sin(a);
  endfunction

  function automatic real rot_y(int x, int y, int z);
    real a = real'($signed(16'(z))) * 2.0 * PI / TURN;
    return real'(x) * $sin(a) + real'(y) * $cos(a);
  endfunction

  task automatic do_rotate(input string req, input int x, input int y, input int z);
    int ox, oy, oz; logic ov;
    run_one(1'b0, x, y, z, ox, oy, oz, ov);
    chk_bit(req, "rotate valid", ov, 1'b1);
    chk_near(req, "rotate x", real'(ox), rot_x(x, y, z), 4.0);
    chk_near(req, "rotate y", real'(oy), rot_y(x, y, z), 4.0);
  endtask

  task automatic do_vector(input int x, input int y);
    int ox, oy, oz; logic ov;
    real mag, ang;
    run_one(1'b1, x, y, 0, ox, oy, oz, ov);
    mag = $sqrt(real'(x) * real'(x) + real'(y) * real'(y));
    ang = $atan2(real'(y), real'(x)) * TURN / (2.0 * PI);
    chk_bit("R3", "vector valid", ov, 1'b1);
    chk_near("R3", "magnitude", real'(ox), mag, 4.0);
    chk_angle("R4", "angle", oz, ang, 4.0);
    chk_near("R9", "residual y", real'(oy), 0.0, 4.0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_bit("R7", "valid after reset", valid_out, 1'b0);
    repeat (LAT + 2) @(negedge clk);
    chk_bit("R7", "valid while idle", valid_out, 1'b0);
  endtask

  task automatic t_rotate_right;
    do_rotate("R2", 20000, 0, 16'h2000);
    do_rotate("R2", 10000, -15000, 16'h0800);
    do_rotate("R2", 18000, 9000, -16'sh1555);
    do_rotate("R2", -5000, 22000, 16'h0000);
  endtask

  task automatic t_angle_code;
    do_rotate("R8", 20000, 0, 16'h4000);
    do_rotate("R8", 20000, 0, 16'hC000);
  endtask

  task automatic t_rotate_left;
    do_rotate("R5", 20000, 5000, 16'h6000);
    do_rotate("R5", 20000, 5000, 16'hA000);
    do_rotate("R5", 15000, -12000, 16'h8000);
    do_rotate("R5", 15000, 0, 16'h7FFF);
  endtask

  task automatic t_vector;
    do_vector(30000, 0);
    do_vector(12000, 17000);
    do_vector(-20000, 5000);
    do_vector(-15000, -15000);
    do_vector(0, -30000);
    do_vector(-32768, 0);
    do_vector(25000, -9000);
  endtask

  // back-to-back stream, gaps every third clock, mode alternating
  task automatic t_stream;
    logic sv [NSTR];
    logic sm [NSTR];
    real  sx [NSTR];
    for (int i = 0; i < NSTR; i++) begin
      int xi = 12000 + i * 100;
      int zi = i * 1500;
      sv[i] = (i % 3) != 0;
      sm[i] = (i % 2) != 0;
      if (sm[i]) sx[i] = $sqrt(real'(xi) * real'(xi) + 9.0e6);
      else       sx[i] = rot_x(xi, 3000, zi);
    end
    for (int c = 0; c < NSTR + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        chk_bit("R1", "stream valid", valid_out, sv[c-LAT]);
        if (sv[c-LAT]) begin
          chk_bit("R6", "stream mode", mode_out, sm[c-LAT]);
          chk_near("R1", "stream x", real'(x_out), sx[c-LAT], 4.0);
        end
      end else begin
        chk_bit("R1", "no early valid", valid_out, 1'b0);
      end
      if (c < NSTR) begin
        valid_in = sv[c];
        mode_in  = sm[c];
        x_in     = DW'(12000 + c * 100);
        y_in     = DW'(3000);
        z_in     = AW'(c * 1500);
      end else begin
        valid_in = 1'b0;
      end
    end
  endtask

  // reset while the pipeline is full: nothing may emerge
  task automatic t_reset_flush;
    @(negedge clk);
    valid_in = 1'b1; mode_in = 1'b0; x_in = 16'sd1000; y_in = 16'sd0; z_in = '0;
    repeat (LAT / 2) @(negedge clk);
    valid_in = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_bit("R7", "valid right after flush", valid_out, 1'b0);
    for (int c = 0; c < LAT + 2; c++) begin
      @(negedge clk);
      chk_bit("R7", "flushed sample emerged", valid_out, 1'b0);
    end
  endtask

  initial begin
    t_reset();
    t_rotate_right();
    t_angle_code();
    t_rotate_left();
    t_vector();
    t_stream();
    t_reset_flush();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule